// File: doc/BRIEF.md
# SDRAM Open-Row Write Sequencer

This block takes write requests from a simple bus master and turns them into SDRAM command cycles. It keeps a small table that records which row is open in each bank. A write that lands in the open row of its bank goes out as a WRITE command in the same cycle the request is presented, so a run of such writes streams at one word per clock. A write to a closed bank first activates the row. A write to a different row of an open bank first precharges that bank, waits a programmable gap, activates the new row, waits a second programmable gap, and then writes. The master also supplies a transfer-type flag. A sequential access that follows a write to the last column of a page is treated as a page crossing and always reopens the row.

The request address is split as `{bank, row, column}` from the most significant bit down. Column width, row width, bank-select width, data width and the width of the gap settings are parameters. The master keeps `req_valid` and its address and data stable until it sees `req_ready` high at a rising edge. The SDRAM clock output enable stays low until the first request. A level-sensitive low-power request closes every bank and puts the device into self-refresh with the clock stopped. Releasing the request wakes the device up again.

States: `ST_IDLE` (waits for a request; issues hit writes directly), `ST_PRE` (bank precharge), `ST_TRP` (precharge-to-activate wait), `ST_ACT` (row activate), `ST_TRCD` (activate-to-write wait), `ST_WR` (write after reopening), `ST_SPRE` (precharge of all banks before self-refresh), `ST_STRP` (wait after that precharge), `ST_SENT` (self-refresh entry command), `ST_SELF` (in self-refresh). The transitions are:
- `ST_IDLE`→`ST_SPRE` on a low-power request. This takes priority over a pending write.
- `ST_IDLE`→`ST_IDLE` on a hit.
- `ST_IDLE`→`ST_PRE` on a miss in an open bank.
- `ST_IDLE`→`ST_ACT` on a closed bank.
- `ST_PRE`→`ST_TRP` or straight to `ST_ACT` when the precharge gap is 1 or less.
- `ST_TRP`→`ST_ACT` when the gap counter expires.
- `ST_ACT`→`ST_TRCD` or straight to `ST_WR` when the activate gap is 1 or less.
- `ST_TRCD`→`ST_WR` when the gap counter expires.
- `ST_WR`→`ST_IDLE`.
- `ST_SPRE`→`ST_STRP` or straight to `ST_SENT`.
- `ST_STRP`→`ST_SENT` when the gap counter expires.
- `ST_SENT`→`ST_SELF`.
- `ST_SELF`→`ST_IDLE` when the low-power request is released.

Top module: `sdram_wr_seq`

## Requirements
- R1: After reset, `req_ready` is low, the command pins {cs_n,ras_n,cas_n,we_n} show NOP = 4'b0111, `sd_cke` is high, and no bank holds an open row.
- R2: `sd_clk_en` stays low from reset until the first request (or low-power request) is seen in idle, and is high whenever a command other than NOP is driven.
- R3: A write to a bank with no open row drives ACTIVATE = 4'b0011 one cycle after the request appears, with `sd_ba` = bank and `sd_a` = row. WRITE = 4'b0100 follows max(cfg_trcd,1) cycles after ACTIVATE, with `sd_a` = column zero-extended (bit 10 low), `sd_ba` = bank and `sd_dq` = data.
- R4: A write to the open row of its bank, with no page crossing, drives WRITE with `req_ready` high in the same cycle that `req_valid` is first high. No precharge or activate is issued.
- R5: Open rows are kept per bank. Opening a row in one bank leaves the open row of every other bank usable as a hit.
- R6: A write to a different row of an open bank drives PRECHARGE = 4'b0010 one cycle after the request, with `sd_ba` = bank and `sd_a[10]` low. ACTIVATE of the new row follows max(cfg_trp,1) cycles later, and WRITE follows max(cfg_trcd,1) cycles after that.
- R7: When `req_seq` is 1 and the previous write went to the last column (all ones), the write runs precharge, activate and write even if its row is open. The same row addressed with `req_seq` = 0 is a direct hit.
- R8: `req_ready` is high exactly in cycles that drive WRITE and low in all precharge, activate and wait cycles.
- R9: A gap setting of 0 or 1 issues the next command in the very next cycle.
- R10: While idle, a high `sr_mode` drives PRECHARGE with `sd_a[10]` high one cycle later. SELF-REFRESH = 4'b0001 with `sd_cke` low follows max(cfg_trp,1) cycles after that. From the next cycle on, `sd_cke` and `sd_clk_en` are both low. All banks are then recorded closed.
- R11: When `sr_mode` goes low in self-refresh, `sd_cke` and `sd_clk_en` are high again from the next cycle, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_seq | input | 1 | Transfer type: 1 = sequential continuation, 0 = new access |
| req_addr | input | BA_W+RB+CB | Address {bank,row,column} |
| req_data | input | DW | Write data |
| cfg_trp | input | CW | Precharge-to-activate gap in cycles |
| cfg_trcd | input | CW | Activate-to-write gap in cycles |
| sr_mode | input | 1 | Low-power request: self-refresh while high |
| req_ready | output | 1 | Write data accepted this cycle |
| sd_clk_en | output | 1 | Enable for the SDRAM clock output |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank select |
| sd_a | output | RB | Multiplexed row/column address |
| sd_dq | output | DW | Write data toward the device |

## Verification
A hit produces its WRITE in the same cycle as the request, because the idle state decodes it combinationally. A closed bank yields ACTIVATE in cycle 1 and WRITE in cycle 1+max(tRCD,1). A miss yields PRECHARGE in cycle 1, ACTIVATE in cycle 1+max(tRP,1), and WRITE a further max(tRCD,1) later. Self-refresh entry has its own timeline: PRECHARGE-all in cycle 1, SELF-REFRESH in cycle 1+max(tRP,1), and clocks off from the cycle after that. The wake-up shows at the first edge after `sr_mode` falls. The bench drives every input on a falling edge and samples 1 ns later. It numbers cycles from the request and records the cycle of each command, then compares those cycle numbers with values computed from the gap settings.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_SREF = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_ACT  = 4'b0011,
        CMD_WR   = 4'b0100,
        CMD_NOP  = 4'b0111
    } sdw_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_TRP,
        ST_ACT,
        ST_TRCD,
        ST_WR,
        ST_SPRE,
        ST_STRP,
        ST_SENT,
        ST_SELF
    } sdw_state_e;

endpackage

// File: rtl/sdw_row_table.sv
module sdw_row_table #(
    parameter int BA_W = 2,
    parameter int RB   = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BA_W-1:0] look_bank,
    output logic            look_valid,
    output logic [RB-1:0]   look_row,
    input  logic            open_en,
    input  logic [BA_W-1:0] open_bank,
    input  logic [RB-1:0]   open_row,
    input  logic            close_en,
    input  logic [BA_W-1:0] close_bank,
    input  logic            clear_all
);
    localparam int NB = 1 << BA_W;

    logic [NB-1:0] valid_vec;
    logic [RB-1:0] row_vec [NB];

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic          v_q;
        logic [RB-1:0] r_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                r_q <= '0;
            end else if (clear_all || (close_en && close_bank == BA_W'(g))) begin
                v_q <= 1'b0;
            end else if (open_en && open_bank == BA_W'(g)) begin
                v_q <= 1'b1;
                r_q <= open_row;
            end
        end

        assign valid_vec[g] = v_q;
        assign row_vec[g]   = r_q;
    end

    assign look_valid = valid_vec[look_bank];
    assign look_row   = row_vec[look_bank];
endmodule

// File: rtl/sdw_gap_cnt.sv
module sdw_gap_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          expired
);
    // A gap of len cycles between commands means len-1 wait states;
    // the wait state in which the count is zero is the last one.
    localparam logic [CW-1:0] TWO = CW'(2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= (len > TWO) ? len - TWO : '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
    import sdw_pkg::*;
#(
    parameter int BA_W = 2,
    parameter int RB   = 13,
    parameter int CB   = 8,
    parameter int DW   = 16,
    parameter int CW   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_seq,
    input  logic [BA_W+RB+CB-1:0]  req_addr,
    input  logic [DW-1:0]          req_data,
    input  logic [CW-1:0]          cfg_trp,
    input  logic [CW-1:0]          cfg_trcd,
    input  logic                   sr_mode,
    output logic                   req_ready,
    output logic                   sd_clk_en,
    output logic                   sd_cke,
    output logic                   sd_cs_n,
    output logic                   sd_ras_n,
    output logic                   sd_cas_n,
    output logic                   sd_we_n,
    output logic [BA_W-1:0]        sd_ba,
    output logic [RB-1:0]          sd_a,
    output logic [DW-1:0]          sd_dq
);
    localparam int              AP_BIT = 10;
    localparam logic [CW-1:0]   ONE    = CW'(1);

    sdw_state_e state_q, state_d;
    sdw_cmd_e   cmd;

    logic [CB-1:0]   req_col;
    logic [RB-1:0]   req_row;
    logic [BA_W-1:0] req_bank;
    logic            look_valid;
    logic [RB-1:0]   look_row;
    logic            last_max_q;
    logic            started_q;
    logic            crossing;
    logic            hit;
    logic            gap_start;
    logic [CW-1:0]   gap_len;
    logic            gap_expired;

    assign req_col  = req_addr[CB-1:0];
    assign req_row  = req_addr[CB +: RB];
    assign req_bank = req_addr[CB+RB +: BA_W];

    sdw_row_table #(.BA_W(BA_W), .RB(RB)) u_rows (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_bank  (req_bank),
        .look_valid (look_valid),
        .look_row   (look_row),
        .open_en    (state_q == ST_ACT),
        .open_bank  (req_bank),
        .open_row   (req_row),
        .close_en   (state_q == ST_PRE),
        .close_bank (req_bank),
        .clear_all  (state_q == ST_SPRE)
    );

    assign gap_start = (state_q == ST_PRE) || (state_q == ST_ACT) || (state_q == ST_SPRE);
    assign gap_len   = (state_q == ST_ACT) ? cfg_trcd : cfg_trp;

    sdw_gap_cnt #(.CW(CW)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (gap_start),
        .len     (gap_len),
        .expired (gap_expired)
    );

    assign crossing = req_seq && last_max_q;
    assign hit      = look_valid && (look_row == req_row) && !crossing;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            last_max_q <= 1'b0;
            started_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cmd == CMD_WR) begin
                last_max_q <= (req_col == {CB{1'b1}});
            end
            if (state_q == ST_IDLE && (req_valid || sr_mode)) begin
                started_q <= 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sr_mode) begin
                    state_d = ST_SPRE;
                end else if (req_valid && !hit) begin
                    state_d = look_valid ? ST_PRE : ST_ACT;
                end
            end
            ST_PRE:  state_d = (cfg_trp > ONE) ? ST_TRP : ST_ACT;
            ST_TRP:  if (gap_expired) state_d = ST_ACT;
            ST_ACT:  state_d = (cfg_trcd > ONE) ? ST_TRCD : ST_WR;
            ST_TRCD: if (gap_expired) state_d = ST_WR;
            ST_WR:   state_d = ST_IDLE;
            ST_SPRE: state_d = (cfg_trp > ONE) ? ST_STRP : ST_SENT;
            ST_STRP: if (gap_expired) state_d = ST_SENT;
            ST_SENT: state_d = ST_SELF;
            ST_SELF: if (!sr_mode) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd       = CMD_NOP;
        sd_ba     = '0;
        sd_a      = '0;
        sd_dq     = '0;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!sr_mode && req_valid && hit) begin
                    cmd       = CMD_WR;
                    sd_ba     = req_bank;
                    sd_a      = RB'(req_col);
                    sd_dq     = req_data;
                    req_ready = 1'b1;
                end
            end
            ST_PRE: begin
                cmd   = CMD_PRE;
                sd_ba = req_bank;
            end
            ST_ACT: begin
                cmd   = CMD_ACT;
                sd_ba = req_bank;
                sd_a  = req_row;
            end
            ST_WR: begin
                cmd       = CMD_WR;
                sd_ba     = req_bank;
                sd_a      = RB'(req_col);
                sd_dq     = req_data;
                req_ready = 1'b1;
            end
            ST_SPRE: begin
                cmd          = CMD_PRE;
                sd_a[AP_BIT] = 1'b1;
            end
            ST_SENT: cmd = CMD_SREF;
            ST_TRP, ST_TRCD, ST_STRP, ST_SELF: cmd = CMD_NOP;
            default: cmd = CMD_NOP;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_cke    = !((state_q == ST_SENT) || (state_q == ST_SELF));
    assign sd_clk_en = started_q && (state_q != ST_SELF);
endmodule

// File: rtl/sdw_wr_seq_chk.sv
module sdw_wr_seq_chk #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [CW-1:0] cfg_trp,
    input logic [CW-1:0] cfg_trcd,
    input logic          sd_cke,
    input logic          sd_clk_en,
    input logic          sd_cs_n,
    input logic          sd_ras_n,
    input logic          sd_cas_n,
    input logic          sd_we_n
);
    logic [3:0] cmd;
    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    AST_READY_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cmd == 4'b0100); // R8
    AST_WRITE_GIVES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0100 |-> req_ready); // R8
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> req_valid); // R4
    AST_TRP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010 && cfg_trp > CW'(1)) |=> cmd == 4'b0111); // R6
    AST_TRCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0011 && cfg_trcd > CW'(1)) |=> cmd == 4'b0111); // R3
    AST_SREF_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0001 |-> !sd_cke); // R10
    AST_CLK_OFF_IN_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cke && cmd != 4'b0001) |-> !sd_clk_en); // R10
    AST_CMD_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != 4'b0111 |-> sd_clk_en); // R2
endmodule

bind sdram_wr_seq sdw_wr_seq_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cfg_trp   (cfg_trp),
    .cfg_trcd  (cfg_trcd),
    .sd_cke    (sd_cke),
    .sd_clk_en (sd_clk_en),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n)
);

// File: tb/sim_sdram_wr_seq.sv
`timescale 1ns/1ps
module sim_sdram_wr_seq;
    localparam int BA_W = 2;
    localparam int RB   = 13;
    localparam int CB   = 8;
    localparam int DW   = 16;
    localparam int CW   = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  req_valid = 1'b0;
    logic                  req_seq = 1'b0;
    logic [BA_W+RB+CB-1:0] req_addr = '0;
    logic [DW-1:0]         req_data = '0;
    logic [CW-1:0]         cfg_trp = CW'(2);
    logic [CW-1:0]         cfg_trcd = CW'(3);
    logic                  sr_mode = 1'b0;
    logic                  req_ready, sd_clk_en, sd_cke;
    logic                  sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [BA_W-1:0]       sd_ba;
    logic [RB-1:0]         sd_a;
    logic [DW-1:0]         sd_dq;

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    sdram_wr_seq #(.BA_W(BA_W), .RB(RB), .CB(CB), .DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seq(req_seq),
        .req_addr(req_addr), .req_data(req_data), .cfg_trp(cfg_trp),
        .cfg_trcd(cfg_trcd), .sr_mode(sr_mode), .req_ready(req_ready),
        .sd_clk_en(sd_clk_en), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq(sd_dq)
    );

    function automatic int cmd_now();
        return int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n});
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int gap(input logic [CW-1:0] v);
        return (v > CW'(1)) ? int'(v) : 1;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            nfail++;
            nvec++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    // mode: 0 = direct hit, 1 = activate then write, 2 = precharge, activate, write
    task automatic write_op(input int bank, input int row, input int col, input bit seq,
                            input int data, input int mode, input string tag);
        int e_pre = -1, e_act = -1, e_wr;
        int pre_k = -1, act_k = -1, wr_k = -1;
        int pre_ba = -1, pre_a10 = -1, act_ba = -1, act_a = -1;
        int wr_ba = -1, wr_a = -1, wr_dq = -1;
        int rdy_cnt = 0, rdy_at_wr = 0, clk_bad = 0;
        if (mode == 0) begin
            e_wr = 0;
        end else if (mode == 1) begin
            e_act = 1;
            e_wr  = 1 + gap(cfg_trcd);
        end else begin
            e_pre = 1;
            e_act = 1 + gap(cfg_trp);
            e_wr  = e_act + gap(cfg_trcd);
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_seq   = seq;
        req_addr  = {BA_W'(bank), RB'(row), CB'(col)};
        req_data  = DW'(data);
        for (int k = 0; k < 40; k++) begin
            #1;
            if (req_ready) rdy_cnt++;
            if (cmd_now() != 7 && !sd_clk_en) clk_bad++;
            if (cmd_now() == 2) begin pre_k = k; pre_ba = int'(sd_ba); pre_a10 = int'(sd_a[10]); end
            if (cmd_now() == 3) begin act_k = k; act_ba = int'(sd_ba); act_a = int'(sd_a); end
            if (cmd_now() == 4) begin
                wr_k = k; wr_ba = int'(sd_ba); wr_a = int'(sd_a); wr_dq = int'(sd_dq);
                rdy_at_wr = int'(req_ready);
                break;
            end
            @(negedge clk);
        end
        check({tag, " precharge cycle"}, pre_k, e_pre);
        check({tag, " activate cycle"}, act_k, e_act);
        check({tag, " write cycle"}, wr_k, e_wr);
        check({tag, " R8 ready cycles"}, rdy_cnt, 1);
        check({tag, " R8 ready at write"}, rdy_at_wr, 1);
        check({tag, " R2 clock before command"}, clk_bad, 0);
        if (mode == 2) begin
            check({tag, " R6 precharge bank"}, pre_ba, bank);
            check({tag, " R6 precharge a10"}, pre_a10, 0);
        end
        if (mode != 0) begin
            check({tag, " R3 activate bank"}, act_ba, bank);
            check({tag, " R3 activate row"}, act_a, row);
        end
        check({tag, " R3 write bank"}, wr_ba, bank);
        check({tag, " R3 write column"}, wr_a, col);
        check({tag, " R3 write data"}, wr_dq, data & 16'hFFFF);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic reset_test();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            check("R1 reset command NOP", cmd_now(), 7);
            check("R1 reset ready low", int'(req_ready), 0);
            check("R1 reset cke high", int'(sd_cke), 1);
            check("R2 clock idle before first access", int'(sd_clk_en), 0);
        end
    endtask

    task automatic self_refresh_test();
        int e_sref;
        e_sref = 1 + gap(cfg_trp);
        @(negedge clk);
        sr_mode = 1'b1;
        for (int k = 0; k <= e_sref + 3; k++) begin
            #1;
            check("R8 R10 ready low in self-refresh", int'(req_ready), 0);
            if (k == 1) begin
                check("R10 precharge-all command", cmd_now(), 2);
                check("R10 precharge-all a10", int'(sd_a[10]), 1);
            end else if (k == e_sref) begin
                check("R10 self-refresh command", cmd_now(), 1);
                check("R10 cke low at entry", int'(sd_cke), 0);
            end else if (k > e_sref) begin
                check("R10 cke low in self-refresh", int'(sd_cke), 0);
                check("R10 clock stopped in self-refresh", int'(sd_clk_en), 0);
            end else begin
                check("R10 NOP between commands", cmd_now(), 7);
            end
            @(negedge clk);
        end
        sr_mode = 1'b0;
        #1;
        check("R11 cke still low in exit cycle", int'(sd_cke), 0);
        @(negedge clk);
        #1;
        check("R11 cke high after exit", int'(sd_cke), 1);
        check("R11 clock running after exit", int'(sd_clk_en), 1);
        check("R11 NOP after exit", cmd_now(), 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reset_test();

        // tRP = 2, tRCD = 3
        write_op(0, 5, 10, 1'b0, 16'h1111, 1, "R1 R3 closed bank");
        write_op(0, 5, 11, 1'b1, 16'h2222, 0, "R4 sequential hit");
        write_op(1, 9, 0, 1'b0, 16'h3333, 1, "R5 second bank open");
        write_op(0, 5, 12, 1'b0, 16'h4444, 0, "R5 bank0 still open");
        write_op(1, 9, 1, 1'b1, 16'h5555, 0, "R5 bank1 still open");
        write_op(0, 7, 0, 1'b0, 16'h6666, 2, "R6 row miss");
        write_op(0, 7, 255, 1'b0, 16'h7777, 0, "R7 last column hit");
        write_op(0, 7, 0, 1'b1, 16'h8888, 2, "R7 sequential page crossing");
        write_op(0, 7, 255, 1'b0, 16'h9999, 0, "R7 last column again");
        write_op(0, 7, 3, 1'b0, 16'hAAAA, 0, "R7 non-sequential after last column");

        @(negedge clk);
        cfg_trp = CW'(1); cfg_trcd = CW'(0);
        write_op(1, 20, 5, 1'b0, 16'hBBBB, 2, "R9 gaps one and zero");
        @(negedge clk);
        cfg_trp = CW'(0); cfg_trcd = CW'(1);
        write_op(1, 21, 6, 1'b0, 16'hCCCC, 2, "R9 gaps zero and one");

        @(negedge clk);
        cfg_trp = CW'(3); cfg_trcd = CW'(2);
        self_refresh_test();
        write_op(1, 21, 7, 1'b0, 16'hDDDD, 1, "R10 bank1 closed after self-refresh");
        write_op(0, 7, 4, 1'b0, 16'hEEEE, 1, "R10 bank0 closed after self-refresh");

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule